// File: doc/BRIEF.md
# Givens-Rotation Matrix Bidiagonalizer

This block takes a 4×4 matrix of signed 16-bit integers and reduces it to upper bidiagonal form, where only the main diagonal and the first superdiagonal may hold nonzero values. Software or a neighbouring block writes the sixteen elements through a word-addressed write port and pulses `start`. The block then works through a fixed list of nine plane rotations: six that combine two rows and three that combine two columns. When it pulses `done`, the result is read back through the same word addressing. Fractional channel values are expected to arrive as integers scaled by 1000, so every input magnitude stays below 4096.

Each rotation uses a shared shift-and-add micro-rotation engine. The first pass of a rotation runs in vectoring mode on the pivot/target element pair. It records a flip bit and one direction bit per iteration, and the target element is then stored as an exact zero. The next three passes replay the same flip and direction bits in rotation mode on the other three element pairs of the two affected lines. Every stored result has the engine gain removed by a constant shift-add and is saturated to 16 bits. Every pair is processed even when both elements are already zero, so the run time is identical for every input.

Top module: `givens_bidiag`

The controller has five states, all named here. `ST_IDLE` waits and accepts writes. `ST_FETCH` loads one element pair into the engine. `ST_SPIN` performs `ITER` micro-rotations. `ST_STORE` writes the pair back. `ST_DONE` raises `done` for one cycle. The transitions are as follows. `ST_IDLE`→`ST_FETCH` on `start`. `ST_FETCH`→`ST_SPIN` always. `ST_SPIN`→`ST_STORE` after the last iteration. `ST_STORE`→`ST_FETCH` while pairs remain. `ST_STORE`→`ST_DONE` after the last pair of the last rotation. `ST_DONE`→`ST_IDLE` always.

## Requirements
- R1: While `busy` is low, a write with `wr_en` high stores `wr_data` at element (row, col) with `wr_addr` = 4·row + col. `rd_data` shows the element selected by `rd_addr` in the same cycle.
- R2: A `start` sampled in idle makes `busy` high for exactly 36·(ITER+2) cycles (504 at ITER=12). `done` then goes high for exactly one cycle with `busy` low, after which the block is idle again. `busy` and `done` are never high together.
- R3: While `busy` is high, `wr_en` and `start` have no effect on the stored matrix or on the timing.
- R4: The rotations run in a fixed order, given as (kind, pivot line, target line). Rows (0,1), (0,2) and (0,3) on column 0. Columns (1,2) and (1,3) on row 0. Rows (1,2) and (1,3) on column 1. Columns (2,3) on row 1. Rows (2,3) on column 2.
- R5: Vectoring pass. The engine takes x = the pivot element and y = the target element. If x < 0, both are negated and the flip bit is set. Then, for i = 0..ITER-1, it records d_i = (y ≥ 0). If d_i is set, x += y>>>i and y -= x>>>i; otherwise x -= y>>>i and y += x>>>i, with both updates using the old values. The pivot receives the scaled x and the target receives exactly 0.
- R6: After vectoring, the other three element pairs of the same two lines are taken in ascending index order. Each receives the same flip and the same d_i sequence, and both elements are stored scaled.
- R7: Scaling is s(v) = (v>>>1)+(v>>>3)−(v>>>6)−(v>>>9), saturated to the range −32768..32767.
- R8: After `done`, every element off the main diagonal and first superdiagonal reads exactly 0.
- R9: For inputs with magnitudes below 4096, the Frobenius norm of the result is within 6% of that of the input.
- R10: After reset, all sixteen elements read 0, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a reduction (idle only) |
| wr_en | input | 1 | Element write strobe (idle only) |
| wr_addr | input | 4 | Element index, 4·row+col |
| wr_data | input | DW | Signed element value |
| rd_addr | input | 4 | Read element index, 4·row+col |
| rd_data | output | DW | Signed element value at `rd_addr` |
| busy | output | 1 | Reduction in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The external write port and the internal write-back in `ST_STORE` both target the same element storage, and they can be active in the same cycle. The bench provokes this by holding `wr_en` and `start` high for sixteen consecutive cycles in the middle of a run. That window is wider than one pair period, so it is certain to overlap a store cycle. The run is judged correct when the result is bit-identical to a bench model computed from the matrix loaded before `start`, and when `busy`/`done` still follow the model's cycle-by-cycle timeline.

// File: rtl/bidiag_pkg.sv
package bidiag_pkg;
    localparam int NSTEP = 9;
    localparam int SIDE  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SPIN,
        ST_STORE,
        ST_DONE
    } state_t;

    typedef struct packed {
        logic       is_col;
        logic [1:0] a;
        logic [1:0] b;
    } plan_t;
endpackage

// File: rtl/bidiag_plan.sv
module bidiag_plan
    import bidiag_pkg::*;
(
    input  logic [3:0] step,
    output plan_t      entry
);
    always_comb begin
        case (step)
            4'd0:    entry = '{is_col: 1'b0, a: 2'd0, b: 2'd1};
            4'd1:    entry = '{is_col: 1'b0, a: 2'd0, b: 2'd2};
            4'd2:    entry = '{is_col: 1'b0, a: 2'd0, b: 2'd3};
            4'd3:    entry = '{is_col: 1'b1, a: 2'd1, b: 2'd2};
            4'd4:    entry = '{is_col: 1'b1, a: 2'd1, b: 2'd3};
            4'd5:    entry = '{is_col: 1'b0, a: 2'd1, b: 2'd2};
            4'd6:    entry = '{is_col: 1'b0, a: 2'd1, b: 2'd3};
            4'd7:    entry = '{is_col: 1'b1, a: 2'd2, b: 2'd3};
            4'd8:    entry = '{is_col: 1'b0, a: 2'd2, b: 2'd3};
            default: entry = '{is_col: 1'b0, a: 2'd0, b: 2'd1};
        endcase
    end
endmodule

// File: rtl/bidiag_micro.sv
module bidiag_micro #(
    parameter int IW  = 19,
    parameter int SW  = 4
) (
    input  logic signed [IW-1:0] x,
    input  logic signed [IW-1:0] y,
    input  logic        [SW-1:0] shift,
    input  logic                 neg,
    output logic signed [IW-1:0] xn,
    output logic signed [IW-1:0] yn
);
    logic signed [IW-1:0] xs, ys;

    always_comb begin
        xs = x >>> shift;
        ys = y >>> shift;
        if (neg) begin
            xn = x + ys;
            yn = y - xs;
        end else begin
            xn = x - ys;
            yn = y + xs;
        end
    end
endmodule

// File: rtl/bidiag_scale.sv
module bidiag_scale #(
    parameter int IW = 19,
    parameter int DW = 16
) (
    input  logic signed [IW-1:0] v,
    output logic        [DW-1:0] q
);
    localparam logic signed [IW-1:0] HI = IW'((64'sd1 <<< (DW-1)) - 1);
    localparam logic signed [IW-1:0] LO = -HI - IW'(1);

    logic signed [IW-1:0] sum;

    always_comb begin
        sum = (v >>> 1) + (v >>> 3) - (v >>> 6) - (v >>> 9);
        if (sum > HI)      q = HI[DW-1:0];
        else if (sum < LO) q = LO[DW-1:0];
        else               q = sum[DW-1:0];
    end
endmodule

// File: rtl/givens_bidiag.sv
module givens_bidiag
    import bidiag_pkg::*;
#(
    parameter int DW   = 16,
    parameter int ITER = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wr_en,
    input  logic [3:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [3:0]    rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          busy,
    output logic          done
);
    localparam int IW    = DW + 3;
    localparam int ITW   = (ITER > 1) ? $clog2(ITER) : 1;
    localparam int NE    = SIDE * SIDE;
    localparam logic [3:0] LAST_STEP = 4'(NSTEP - 1);

    state_t              state_q, state_d;
    logic [NE-1:0][DW-1:0] mat_q;
    logic [3:0]          step_q;
    logic [1:0]          pass_q;
    logic [ITW-1:0]      iter_q;
    logic signed [IW-1:0] x_q, y_q, xn, yn, px, ty;
    logic                flip_q;
    logic [ITER-1:0]     dirs_q;
    plan_t               plan;
    logic [1:0]          k, j;
    logic [3:0]          pidx, tidx;
    logic                vec, dir, fl, last_pair;
    logic [DW-1:0]       xs_q, ys_q;

    bidiag_plan u_plan (.step(step_q), .entry(plan));

    bidiag_micro #(.IW(IW), .SW(ITW)) u_micro (
        .x(x_q), .y(y_q), .shift(iter_q), .neg(dir), .xn(xn), .yn(yn)
    );

    bidiag_scale #(.IW(IW), .DW(DW)) u_scale_x (.v(x_q), .q(xs_q));
    bidiag_scale #(.IW(IW), .DW(DW)) u_scale_y (.v(y_q), .q(ys_q));

    // Element pair addressing for the current rotation and pass
    always_comb begin
        k   = plan.is_col ? (plan.a - 2'd1) : plan.a;
        vec = (pass_q == 2'd0);
        if (vec)                    j = k;
        else if ((pass_q - 2'd1) < k) j = pass_q - 2'd1;
        else                        j = pass_q;
        pidx = plan.is_col ? {j, plan.a} : {plan.a, j};
        tidx = plan.is_col ? {j, plan.b} : {plan.b, j};
        px   = IW'($signed(mat_q[pidx]));
        ty   = IW'($signed(mat_q[tidx]));
        fl   = vec ? px[IW-1] : flip_q;
        dir  = vec ? ~y_q[IW-1] : dirs_q[iter_q];
        last_pair = (step_q == LAST_STEP) && (pass_q == 2'd3);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_FETCH;
            ST_FETCH: state_d = ST_SPIN;
            ST_SPIN:  if (iter_q == ITW'(ITER - 1)) state_d = ST_STORE;
            ST_STORE: state_d = last_pair ? ST_DONE : ST_FETCH;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy    = 1'b0;
        done    = 1'b0;
        rd_data = mat_q[rd_addr];
        unique case (state_q)
            ST_FETCH, ST_SPIN, ST_STORE: busy = 1'b1;
            ST_DONE:                     done = 1'b1;
            default: ;
        endcase
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mat_q  <= '0;
            step_q <= '0;
            pass_q <= '0;
            iter_q <= '0;
            x_q    <= '0;
            y_q    <= '0;
            flip_q <= 1'b0;
            dirs_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (wr_en) mat_q[wr_addr] <= wr_data;
                    if (state_q == ST_IDLE && start) begin
                        step_q <= '0;
                        pass_q <= '0;
                    end
                end
                ST_FETCH: begin
                    x_q    <= fl ? -px : px;
                    y_q    <= fl ? -ty : ty;
                    flip_q <= fl;
                    iter_q <= '0;
                end
                ST_SPIN: begin
                    x_q <= xn;
                    y_q <= yn;
                    if (vec) dirs_q[iter_q] <= dir;
                    iter_q <= iter_q + ITW'(1);
                end
                ST_STORE: begin
                    mat_q[pidx] <= xs_q;
                    mat_q[tidx] <= vec ? '0 : ys_q;
                    pass_q <= pass_q + 2'd1;
                    if (pass_q == 2'd3) step_q <= step_q + 4'd1;
                end
                default: ;
            endcase
        end
    end

    // R2: done is a single-cycle pulse
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R2: busy and done are exclusive
    p_busy_done_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    // R2: done only follows the final write-back
    p_done_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(state_q == ST_STORE && step_q == LAST_STEP && pass_q == 2'd3));
    // R3: no external write reaches the matrix while busy
    p_no_write_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state_q != ST_STORE) |=> $stable(mat_q));
    // R5: the vectored target is stored as an exact zero
    p_target_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STORE && pass_q == 2'd0) |=> (mat_q[$past(tidx)] == '0));
endmodule

// File: tb/givens_bidiag_test.sv
module givens_bidiag_test;
    localparam int DW   = 16;
    localparam int ITER = 12;
    localparam int LAT  = 36 * (ITER + 2);
    localparam int HI   = (1 << (DW - 1)) - 1;
    localparam int LO   = -(1 << (DW - 1));

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [3:0]    rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          busy, done;

    int checks = 0;
    int fails  = 0;
    int mat_in [16];
    int exp_m  [16];
    int sc_col [9] = '{0,0,0,1,1,0,0,1,0};
    int sc_a   [9] = '{0,0,0,1,1,1,1,2,2};
    int sc_b   [9] = '{1,2,3,2,3,2,3,3,3};

    givens_bidiag #(.DW(DW), .ITER(ITER)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy), .done(done)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int scl(input int v);
        int s;
        s = (v >>> 1) + (v >>> 3) - (v >>> 6) - (v >>> 9);
        if (s > HI) s = HI;
        if (s < LO) s = LO;
        return s;
    endfunction

    function automatic int eaddr(input int col, input int line, input int j);
        return (col != 0) ? (j * 4 + line) : (line * 4 + j);
    endfunction

    // Behavioural model of R4..R7
    task automatic model();
        for (int e = 0; e < 16; e++) exp_m[e] = mat_in[e];
        for (int s = 0; s < 9; s++) begin
            int kk, x, y, pa, ta, xo;
            bit fl;
            bit d [ITER];
            kk = (sc_col[s] != 0) ? sc_a[s] - 1 : sc_a[s];
            pa = eaddr(sc_col[s], sc_a[s], kk);
            ta = eaddr(sc_col[s], sc_b[s], kk);
            x = exp_m[pa]; y = exp_m[ta];
            fl = (x < 0);
            if (fl) begin x = -x; y = -y; end
            for (int i = 0; i < ITER; i++) begin
                d[i] = (y >= 0);
                xo = x;
                if (d[i]) begin x = x + (y >>> i); y = y - (xo >>> i); end
                else      begin x = x - (y >>> i); y = y + (xo >>> i); end
            end
            exp_m[pa] = scl(x);
            exp_m[ta] = 0;
            for (int jj = 0; jj < 4; jj++) begin
                if (jj != kk) begin
                    pa = eaddr(sc_col[s], sc_a[s], jj);
                    ta = eaddr(sc_col[s], sc_b[s], jj);
                    x = exp_m[pa]; y = exp_m[ta];
                    if (fl) begin x = -x; y = -y; end
                    for (int i = 0; i < ITER; i++) begin
                        xo = x;
                        if (d[i]) begin x = x + (y >>> i); y = y - (xo >>> i); end
                        else      begin x = x - (y >>> i); y = y + (xo >>> i); end
                    end
                    exp_m[pa] = scl(x);
                    exp_m[ta] = scl(y);
                end
            end
        end
    endtask

    task automatic rd(input int idx, output int v);
        rd_addr = 4'(idx);
        #1;
        v = int'($signed(rd_data));
    endtask

    task automatic load();
        int v;
        for (int e = 0; e < 16; e++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 4'(e); wr_data = DW'(mat_in[e]);
        end
        @(negedge clk);
        wr_en = 1'b0;
        rd(5, v);
        chk(v == mat_in[5], "R1 readback", v, mat_in[5]);
        rd(12, v);
        chk(v == mat_in[12], "R1 readback", v, mat_in[12]);
    endtask

    task automatic run_case(input string name, input bit inject, input bit normchk);
        int v;
        real n_in, n_out;
        model();
        @(negedge clk);
        start = 1'b1;
        for (int cyc = 1; cyc <= LAT; cyc++) begin
            @(negedge clk);
            if (inject && cyc >= 100 && cyc < 116) begin
                start = 1'b1; wr_en = 1'b1; wr_addr = 4'(cyc); wr_data = 16'h1234;
            end else begin
                start = 1'b0; wr_en = 1'b0;
            end
            chk(busy && !done, {"R2 busy window ", name}, int'({busy, done}), 2);
        end
        @(negedge clk);
        start = 1'b0; wr_en = 1'b0;
        chk(done && !busy, {"R2 done pulse ", name}, int'({busy, done}), 1);
        @(negedge clk);
        chk(!done && !busy, {"R2 back to idle ", name}, int'({busy, done}), 0);
        n_in = 0.0; n_out = 0.0;
        for (int e = 0; e < 16; e++) begin
            rd(e, v);
            chk(v == exp_m[e], {"R4 R5 R6 R7 R3 element ", name}, v, exp_m[e]);
            if ((e % 4) != (e / 4) && (e % 4) != (e / 4) + 1)
                chk(v == 0, {"R8 off-band ", name}, v, 0);
            n_in  += real'(mat_in[e]) * real'(mat_in[e]);
            n_out += real'(v) * real'(v);
        end
        if (normchk && n_in > 0.0)
            chk(n_out >= 0.8836 * n_in && n_out <= 1.1236 * n_in,
                {"R9 norm ", name}, int'(n_out), int'(n_in));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R10 reset flags", int'({busy, done}), 0);
        for (int e = 0; e < 16; e++) begin
            rd(e, v);
            chk(v == 0, "R10 reset element", v, 0);
        end

        // Fixed positive pattern
        for (int e = 0; e < 16; e++) mat_in[e] = 100 * (e + 1);
        load();
        run_case("ramp", 1'b0, 1'b1);

        // Negative pivots exercise the flip rule (R5, R6)
        for (int e = 0; e < 16; e++) mat_in[e] = ((e % 3) == 0) ? -(e * 211 + 57) : (e * 97 - 800);
        load();
        run_case("signs", 1'b0, 1'b1);

        // Already diagonal input
        for (int e = 0; e < 16; e++) mat_in[e] = ((e % 5) == 0) ? 2000 - e * 50 : 0;
        load();
        run_case("diag", 1'b0, 1'b1);

        // Random matrices
        for (int t = 0; t < 3; t++) begin
            for (int e = 0; e < 16; e++) mat_in[e] = int'($urandom_range(8190)) - 4095;
            load();
            run_case("random", 1'b0, 1'b1);
        end

        // Collision of external write/start with internal write-back (R3)
        for (int e = 0; e < 16; e++) mat_in[e] = int'($urandom_range(8190)) - 4095;
        load();
        run_case("inject", 1'b1, 1'b1);

        // Saturation of the gain-corrected result (R7)
        for (int e = 0; e < 16; e++) mat_in[e] = ((e % 4) == 0) ? 30000 : -30000;
        load();
        run_case("saturate", 1'b0, 1'b0);
        rd(0, v);
        chk(v == HI, "R7 saturated pivot", v, HI);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule